// File: doc/BRIEF.md
# Coherency Unit Configuration Register Bank

This block is the small register file that software uses to configure and inspect the coherency unit shared by one to four processor cores. It is reached over a plain register bus. Each request carries a byte offset inside a 256-byte window, an access size in bytes, a write strobe or a read strobe, and 32-bit write data. Read data comes back from a register one clock after the read strobe.

The bank stores two things: a single enable bit, and a 32-bit per-core power status word. The power status word can be updated one byte, one halfword or one word at a time, starting at any of its four byte offsets. The bank also reports a read-only identification word that is computed from the core-count parameter. It gives a presence bit for each core and the core count minus one. Every other offset in the window reads as zero and ignores writes. This covers the filter-range, security-access and invalidate locations as well as every unmapped offset.

Top module: `coh_cfg_regs`

## Requirements
- R1: After reset the enable bit, the power status word, the read data output and the error output are all zero.
- R2: A write to offset 0x00 stores only write-data bit 0 as the enable bit; a read of 0x00 returns that bit in bit 0 with bits 31:1 zero.
- R3: A read of offset 0x04 returns ((2^N − 1) << 4) | (N − 1) for NUM_CORES = N in 1..4 (0x10, 0x31, 0x72, 0xF3); writes to 0x04 change no state.
- R4: A write at offset 0x08+k (k = 0..3) replaces only the power status bits selected by the size mask shifted left by 8·k, with the masked write data shifted left by the same amount; bits shifted past bit 31 are dropped and all other bits keep their value.
- R5: A read at offset 0x08+k returns the power status word shifted right by 8·k with zero fill.
- R6: The size input is a byte count: 1 gives mask 0xFF, 2 gives mask 0xFFFF, 4 gives mask 0xFFFFFFFF; a write with any other size value changes no register.
- R7: A write with an illegal size raises the error output for exactly the one clock after the write strobe; legal writes and reads leave it low.
- R8: Offsets other than 0x00, 0x04 and 0x08–0x0B (including 0x0C, 0x40, 0x44, 0x50, 0x54) read as zero, and writes to them change no register.
- R9: Read data is registered: it reflects the state before any write in the same cycle, appears one clock after the read strobe, and holds its value while no read is requested.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Byte offset within the 256-byte window |
| bus_size | input | 3 | Access size in bytes (1, 2 or 4 legal) |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_err | output | 1 | One-clock pulse after a write with an illegal size |

## Verification
The assertions assume that the bus inputs are at a defined level on every clock edge after reset. They also assume that the register state is exercised only through the strobes, so that a stable power word can be tied to the absence of a legal write. The bench drives every input from a task at the falling edge and returns the strobes to zero after one cycle, so each input is known and settled at every rising edge. Reads and writes are issued together only in the single directed test that examines ordering.

// File: rtl/coh_cfg_regs_pkg.sv
package coh_cfg_regs_pkg;

    localparam int DW    = 32;
    localparam int OFS_W = 8;

    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_CFG  = 2'd1,
        SEL_PWR  = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic          ctrl;
        logic [DW-1:0] pwr;
        logic [DW-1:0] rdata;
        logic          err;
    } bank_t;

    // Identification word: one presence bit per core from bit 4, count-1 in low bits.
    function automatic logic [DW-1:0] cfg_word(input int n);
        logic [DW-1:0] w;
        w = DW'(((1 << n) - 1) << 4) | DW'(n - 1);
        return w;
    endfunction

endpackage

// File: rtl/coh_addr_dec.sv
module coh_addr_dec
    import coh_cfg_regs_pkg::*;
(
    input  logic [OFS_W-1:0] addr,
    output reg_sel_e         sel,
    output logic [1:0]       lane
);
    always_comb begin
        lane = addr[1:0];
        unique case (addr)
            8'h00:                      sel = SEL_CTRL;
            8'h04:                      sel = SEL_CFG;
            8'h08, 8'h09, 8'h0A, 8'h0B: sel = SEL_PWR;
            default:                    sel = SEL_NONE;
        endcase
    end
endmodule

// File: rtl/coh_wr_mask.sv
module coh_wr_mask
    import coh_cfg_regs_pkg::*;
(
    input  logic [2:0]    size,
    input  logic [1:0]    lane,
    input  logic [DW-1:0] wdata,
    output logic          size_ok,
    output logic [DW-1:0] repl_mask,
    output logic [DW-1:0] repl_data
);
    logic [DW-1:0] base_mask;
    logic [4:0]    sh;

    always_comb begin
        size_ok = 1'b1;
        case (size)
            3'd1:    base_mask = DW'(32'h0000_00FF);
            3'd2:    base_mask = DW'(32'h0000_FFFF);
            3'd4:    base_mask = {DW{1'b1}};
            default: begin
                base_mask = '0;
                size_ok   = 1'b0;
            end
        endcase
        sh        = {lane, 3'b000};
        repl_mask = base_mask << sh;
        repl_data = (wdata & base_mask) << sh;
    end
endmodule

// File: rtl/coh_rd_mux.sv
module coh_rd_mux
    import coh_cfg_regs_pkg::*;
(
    input  reg_sel_e      sel,
    input  logic [1:0]    lane,
    input  logic          ctrl,
    input  logic [DW-1:0] pwr,
    input  logic [DW-1:0] cfg,
    output logic [DW-1:0] rd_word
);
    always_comb begin
        case (sel)
            SEL_CTRL: rd_word = {{(DW-1){1'b0}}, ctrl};
            SEL_CFG:  rd_word = cfg;
            SEL_PWR:  rd_word = pwr >> {lane, 3'b000};
            default:  rd_word = '0;
        endcase
    end
endmodule

// File: rtl/coh_cfg_regs.sv
module coh_cfg_regs
    import coh_cfg_regs_pkg::*;
#(
    parameter int NUM_CORES = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [7:0]  bus_addr,
    input  logic [2:0]  bus_size,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        bus_err
);
    localparam logic [DW-1:0] CFG_WORD = cfg_word(NUM_CORES);

    reg_sel_e      sel;
    logic [1:0]    lane;
    logic          size_ok;
    logic [DW-1:0] repl_mask;
    logic [DW-1:0] repl_data;
    logic [DW-1:0] rd_word;
    bank_t         bank_d, bank_q;

    coh_addr_dec u_dec (
        .addr (bus_addr),
        .sel  (sel),
        .lane (lane)
    );

    coh_wr_mask u_mask (
        .size      (bus_size),
        .lane      (lane),
        .wdata     (bus_wdata),
        .size_ok   (size_ok),
        .repl_mask (repl_mask),
        .repl_data (repl_data)
    );

    coh_rd_mux u_mux (
        .sel     (sel),
        .lane    (lane),
        .ctrl    (bank_q.ctrl),
        .pwr     (bank_q.pwr),
        .cfg     (CFG_WORD),
        .rd_word (rd_word)
    );

    always_comb begin
        bank_d     = bank_q;
        bank_d.err = bus_wr & ~size_ok;
        if (bus_wr && size_ok) begin
            case (sel)
                SEL_CTRL: bank_d.ctrl = bus_wdata[0];
                SEL_PWR:  bank_d.pwr  = (bank_q.pwr & ~repl_mask) | repl_data;
                default:  ;
            endcase
        end
        if (bus_rd) begin
            bank_d.rdata = rd_word;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign bus_rdata = bank_q.rdata;
    assign bus_err   = bank_q.err;

    AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> $past(bus_wr && !size_ok)); // R7
    AST_BAD_SIZE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !size_ok) |=> ($stable(bank_q.pwr) && $stable(bank_q.ctrl))); // R6
    AST_PWR_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> $stable(bank_q.pwr)); // R4
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata)); // R9
    AST_CFG_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == 8'h04) |=> (bus_rdata == CFG_WORD)); // R3
    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && sel == SEL_NONE) |=> (bus_rdata == '0)); // R8
    AST_CTRL_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == 8'h00) |=> (bus_rdata[31:1] == '0)); // R2

endmodule

// File: tb/coh_cfg_regs_tb.sv
module coh_cfg_regs_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 36;

    typedef struct packed {
        logic        wr;
        logic [2:0]  size;
        logic [7:0]  addr;
        logic [31:0] data;
        logic        err;
        logic [3:0]  req;
    } vec_t;

    // Read entries compare data with bus_rdata; every entry compares err.
    localparam vec_t VECS [NV] = '{
        '{1'b0, 3'd4, 8'h00, 32'h0000_0000, 1'b0, 4'd1},  // R1 ctrl clear
        '{1'b0, 3'd4, 8'h08, 32'h0000_0000, 1'b0, 4'd1},  // R1 pwr clear
        '{1'b1, 3'd4, 8'h00, 32'hFFFF_FFFF, 1'b0, 4'd2},  // R2
        '{1'b0, 3'd4, 8'h00, 32'h0000_0001, 1'b0, 4'd2},
        '{1'b1, 3'd1, 8'h00, 32'h0000_0002, 1'b0, 4'd2},
        '{1'b0, 3'd4, 8'h00, 32'h0000_0000, 1'b0, 4'd2},
        '{1'b1, 3'd4, 8'h08, 32'h1122_3344, 1'b0, 4'd4},  // R4 word
        '{1'b0, 3'd4, 8'h08, 32'h1122_3344, 1'b0, 4'd4},
        '{1'b0, 3'd1, 8'h09, 32'h0011_2233, 1'b0, 4'd5},  // R5
        '{1'b0, 3'd1, 8'h0A, 32'h0000_1122, 1'b0, 4'd5},
        '{1'b0, 3'd1, 8'h0B, 32'h0000_0011, 1'b0, 4'd5},
        '{1'b1, 3'd1, 8'h09, 32'hAABB_CCDD, 1'b0, 4'd4},  // R4 byte
        '{1'b0, 3'd4, 8'h08, 32'h1122_DD44, 1'b0, 4'd4},
        '{1'b1, 3'd2, 8'h0A, 32'h5555_BEEF, 1'b0, 4'd4},  // R4 halfword
        '{1'b0, 3'd4, 8'h08, 32'hBEEF_DD44, 1'b0, 4'd4},
        '{1'b1, 3'd4, 8'h0B, 32'h1234_5678, 1'b0, 4'd4},  // R4 truncated word
        '{1'b0, 3'd4, 8'h08, 32'h78EF_DD44, 1'b0, 4'd4},
        '{1'b1, 3'd3, 8'h08, 32'hFFFF_FFFF, 1'b1, 4'd6},  // R6 size 3
        '{1'b0, 3'd4, 8'h08, 32'h78EF_DD44, 1'b0, 4'd6},
        '{1'b1, 3'd0, 8'h08, 32'h0000_0000, 1'b1, 4'd6},  // R6 size 0
        '{1'b0, 3'd4, 8'h08, 32'h78EF_DD44, 1'b0, 4'd6},
        '{1'b1, 3'd7, 8'h00, 32'h0000_0001, 1'b1, 4'd6},  // R6 size 7 on ctrl
        '{1'b0, 3'd4, 8'h00, 32'h0000_0000, 1'b0, 4'd6},
        '{1'b1, 3'd4, 8'h04, 32'h0000_0000, 1'b0, 4'd3},  // R3 write ignored
        '{1'b0, 3'd4, 8'h04, 32'h0000_00F3, 1'b0, 4'd3},
        '{1'b1, 3'd4, 8'h0C, 32'hFFFF_FFFF, 1'b0, 4'd8},  // R8
        '{1'b0, 3'd4, 8'h0C, 32'h0000_0000, 1'b0, 4'd8},
        '{1'b1, 3'd4, 8'h40, 32'hFFFF_FFFF, 1'b0, 4'd8},
        '{1'b0, 3'd4, 8'h40, 32'h0000_0000, 1'b0, 4'd8},
        '{1'b1, 3'd4, 8'h44, 32'hFFFF_FFFF, 1'b0, 4'd8},
        '{1'b0, 3'd4, 8'h44, 32'h0000_0000, 1'b0, 4'd8},
        '{1'b1, 3'd4, 8'h50, 32'hFFFF_FFFF, 1'b0, 4'd8},
        '{1'b0, 3'd4, 8'h54, 32'h0000_0000, 1'b0, 4'd8},
        '{1'b0, 3'd4, 8'hFC, 32'h0000_0000, 1'b0, 4'd8},
        '{1'b0, 3'd4, 8'h00, 32'h0000_0000, 1'b0, 4'd8},
        '{1'b0, 3'd4, 8'h08, 32'h78EF_DD44, 1'b0, 4'd8}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [2:0]  bus_size = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] rd_n [4];
    logic        err_n [4];

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    coh_cfg_regs #(.NUM_CORES(4)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_size(bus_size),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
        .bus_rdata(rd_n[3]), .bus_err(err_n[3])
    );

    for (genvar k = 0; k < 3; k++) begin : g_cfg
        coh_cfg_regs #(.NUM_CORES(k+1)) u_cfg (
            .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_size(bus_size),
            .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
            .bus_rdata(rd_n[k]), .bus_err(err_n[k])
        );
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    // Drive at falling edge; result sampled at the next falling edge.
    task automatic op(input logic wr, input logic rd, input logic [2:0] sz,
                      input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = wr; bus_rd = rd; bus_size = sz; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1", rd_n[3], 32'h0);
        check("R1", {31'd0, err_n[3]}, 32'h0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            op(VECS[i].wr, !VECS[i].wr, VECS[i].size, VECS[i].addr, VECS[i].data);
            if (!VECS[i].wr)
                check($sformatf("R%0d vec %0d", VECS[i].req, i), rd_n[3], VECS[i].data);
            check($sformatf("R%0d err vec %0d", VECS[i].req, i), {31'd0, err_n[3]}, {31'd0, VECS[i].err});
        end

        // R3: identification word for every legal core count
        op(1'b0, 1'b1, 3'd4, 8'h04, 32'h0);
        check("R3 N=1", rd_n[0], 32'h0000_0010);
        check("R3 N=2", rd_n[1], 32'h0000_0031);
        check("R3 N=3", rd_n[2], 32'h0000_0072);
        check("R3 N=4", rd_n[3], 32'h0000_00F3);

        // R7: error pulse lasts one clock
        op(1'b1, 1'b0, 3'd5, 8'h08, 32'h0);
        check("R7 pulse", {31'd0, err_n[3]}, 32'h1);
        @(negedge clk);
        check("R7 drop", {31'd0, err_n[3]}, 32'h0);

        // R9: same-cycle read sees old value, then output holds while idle
        op(1'b1, 1'b1, 3'd4, 8'h08, 32'hCAFE_0001);
        check("R9 old value", rd_n[3], 32'h78EF_DD44);
        repeat (3) @(negedge clk);
        check("R9 hold", rd_n[3], 32'h78EF_DD44);
        op(1'b0, 1'b1, 3'd4, 8'h08, 32'h0);
        check("R9 new value", rd_n[3], 32'hCAFE_0001);

        // R1: reset in the middle of operation
        op(1'b1, 1'b0, 3'd4, 8'h00, 32'h1);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 rdata", rd_n[3], 32'h0);
        rst_n = 1'b1;
        op(1'b0, 1'b1, 3'd4, 8'h00, 32'h0);
        check("R1 ctrl", rd_n[3], 32'h0);
        op(1'b0, 1'b1, 3'd4, 8'h08, 32'h0);
        check("R1 pwr", rd_n[3], 32'h0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule